// File: doc/BRIEF.md
# Serial Command Register Interface

This block takes 8-bit commands from a host controller over a three-wire serial link: an active-low chip select, a serial clock and a serial data line. All three are sampled by the system clock. Each one passes through a two-flop synchronizer, and the block finds its edges from the synchronized levels.

While chip select is low, each falling edge of the serial clock shifts one data bit into a shift register, least significant bit first. A saturating counter counts these edges. When chip select rises, the shifted byte moves into the command register, but only if exactly eight edges were counted.

Each command bit drives one output-enable line. A per-channel fault clear zeroes a channel's bit. A fault clear happens when the output stage reports a short circuit and overtemperature in the same cycle, and it wins over a command that commits in that cycle. A standby flag shows that every enable is off. Two single-cycle strobes report malformed frames to the status logic: one for a short frame and one for a ninth clock.

Top module: `serial_cmd_if`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `cmd_en_o` is all zero, `standby_o` is 1 and both strobes are 0.
- R2: In a frame with exactly eight serial clock falling edges, the first bit sent lands in bit 0 of `cmd_en_o` and the eighth bit sent lands in bit 7.
- R3: Serial clock edges while chip select is high shift nothing, count nothing and leave `cmd_en_o` unchanged.
- R4: A frame with fewer than eight falling edges, including zero, leaves `cmd_en_o` unchanged.
- R5: A frame with more than eight falling edges leaves `cmd_en_o` unchanged. This holds for 16 and 24 edges, where a 4-bit counter would wrap.
- R6: `standby_o` is 1 exactly when every bit of `cmd_en_o` is 0.
- R7: A channel whose `short_i` and `hot_i` bits are both 1 has its `cmd_en_o` bit cleared one cycle later. The bit stays 0 after the fault goes away, until a new command is committed. Only one of the two flags clears nothing.
- R8: When a fault clear and a command commit fall in the same cycle, the faulted channel ends at 0. The other channels take the command value.
- R9: `short_frame_o` pulses for one cycle when chip select rises after fewer than eight falling edges. It does not pulse for a frame of exactly eight.
- R10: `ninth_clk_o` pulses for one cycle on the ninth falling edge of a frame. It pulses only once per frame, however many more edges follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cs_n_i | input | 1 | Serial chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, data taken on its falling edge, asynchronous |
| sdi_i | input | 1 | Serial data, LSB first, asynchronous |
| short_i | input | 8 | Per-channel short-circuit flag |
| hot_i | input | 8 | Per-channel overtemperature flag |
| cmd_en_o | output | 8 | Output-enable lines, 1 = channel on |
| standby_o | output | 1 | All channels off |
| short_frame_o | output | 1 | Pulse: frame ended with fewer than eight clocks |
| ninth_clk_o | output | 1 | Pulse: ninth clock seen in a frame |

## Verification
Two functions can land in the same cycle: the fault clear of a channel and the commit of a new command. The bench holds a short-plus-overtemperature fault on one channel for the whole of a valid frame whose byte sets that channel. The commit cycle therefore always sees the clear. The result must be the command with that channel forced to 0, and the channel must stay 0 after the fault is removed. A short-only fault is applied the same way to show that one flag alone does not clear.

// File: rtl/scmd_pkg.sv
package scmd_pkg;
    localparam int CMD_W   = 8;
    localparam int CNT_W   = 4;
    localparam int SYNC_W  = 3;

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic sdi;
    } ser_t;

    typedef struct packed {
        logic commit;
        logic short_frame;
        logic ninth;
    } frame_evt_t;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
    endfunction
endpackage

// File: rtl/scmd_sync.sv
module scmd_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= rst_val;
            sync_q <= rst_val;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/scmd_frame.sv
module scmd_frame
    import scmd_pkg::*;
#(
    parameter int N  = CMD_W,
    parameter int CW = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  ser_t         ser_i,
    output logic [N-1:0] byte_o,
    output frame_evt_t   evt_o
);
    localparam logic [CW-1:0] FULL = CW'(N);

    logic [N-1:0]  sr_q;
    logic [CW-1:0] cnt_q;
    logic          cs_n_d;
    logic          sclk_d;
    logic          short_q;
    logic          ninth_q;
    logic          cs_fall;
    logic          cs_rise;
    logic          sclk_fall;

    assign cs_fall   = cs_n_d & ~ser_i.cs_n;
    assign cs_rise   = ~cs_n_d & ser_i.cs_n;
    assign sclk_fall = sclk_d & ~ser_i.sclk & ~ser_i.cs_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q    <= '0;
            cnt_q   <= '0;
            cs_n_d  <= 1'b1;
            sclk_d  <= 1'b0;
            short_q <= 1'b0;
            ninth_q <= 1'b0;
        end else begin
            cs_n_d  <= ser_i.cs_n;
            sclk_d  <= ser_i.sclk;
            short_q <= cs_rise && (cnt_q < FULL);
            ninth_q <= sclk_fall && (cnt_q == FULL);
            if (cs_fall) begin
                cnt_q <= '0;
            end else if (sclk_fall) begin
                cnt_q <= sat_inc(cnt_q);
                if (cnt_q < FULL) begin
                    sr_q <= {ser_i.sdi, sr_q[N-1:1]};
                end
            end
        end
    end

    assign byte_o            = sr_q;
    assign evt_o.commit      = cs_rise && (cnt_q == FULL);
    assign evt_o.short_frame = short_q;
    assign evt_o.ninth       = ninth_q;
endmodule

// File: rtl/scmd_cmd_reg.sv
module scmd_cmd_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [N-1:0] data_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] cmd_o
);
    logic [N-1:0] cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (clr_i[i])       cmd_q[i] <= 1'b0;
                else if (load_i)    cmd_q[i] <= data_i[i];
            end
        end
    end

    assign cmd_o = cmd_q;
endmodule

// File: rtl/serial_cmd_if.sv
module serial_cmd_if
    import scmd_pkg::*;
#(
    parameter int N = CMD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_n_i,
    input  logic         sclk_i,
    input  logic         sdi_i,
    input  logic [N-1:0] short_i,
    input  logic [N-1:0] hot_i,
    output logic [N-1:0] cmd_en_o,
    output logic         standby_o,
    output logic         short_frame_o,
    output logic         ninth_clk_o
);
    localparam ser_t SER_IDLE = '{cs_n: 1'b1, sclk: 1'b0, sdi: 1'b0};

    ser_t         ser_raw;
    ser_t         ser_s;
    logic [N-1:0] byte_w;
    frame_evt_t   evt_w;
    logic [N-1:0] fault_clr;
    logic         commit_w;

    assign ser_raw   = '{cs_n: cs_n_i, sclk: sclk_i, sdi: sdi_i};
    assign fault_clr = short_i & hot_i;

    scmd_sync #(.W(SYNC_W)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (ser_raw),
        .rst_val (SER_IDLE),
        .sync_o  (ser_s)
    );

    scmd_frame #(.N(N), .CW(CNT_W)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .ser_i  (ser_s),
        .byte_o (byte_w),
        .evt_o  (evt_w)
    );

    assign commit_w = evt_w.commit;

    scmd_cmd_reg #(.N(N)) u_cmd (
        .clk    (clk),
        .rst    (rst),
        .load_i (commit_w),
        .data_i (byte_w),
        .clr_i  (fault_clr),
        .cmd_o  (cmd_en_o)
    );

    assign standby_o     = (cmd_en_o == '0);
    assign short_frame_o = evt_w.short_frame;
    assign ninth_clk_o   = evt_w.ninth;
endmodule

// File: rtl/scmd_checker.sv
module scmd_checker #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] short_i,
    input logic [N-1:0] hot_i,
    input logic [N-1:0] cmd_en_o,
    input logic         standby_o,
    input logic         commit_w,
    input logic         short_frame_o,
    input logic         ninth_clk_o
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (cmd_en_o == '0 && !short_frame_o && !ninth_clk_o));

    a_r7_fault_clears: assert property (@(posedge clk) disable iff (rst)
        ((short_i & hot_i) != '0) |=> ((cmd_en_o & $past(short_i & hot_i)) == '0));

    a_r4_change_needs_cause: assert property (@(posedge clk) disable iff (rst)
        (cmd_en_o != $past(cmd_en_o)) |-> ($past(commit_w) || ($past(short_i & hot_i) != '0)));

    a_r9_short_pulse: assert property (@(posedge clk) disable iff (rst)
        short_frame_o |=> !short_frame_o);

    a_r10_ninth_pulse: assert property (@(posedge clk) disable iff (rst)
        ninth_clk_o |=> !ninth_clk_o);

    a_r6_standby_flag: assert property (@(posedge clk) disable iff (rst)
        $fell(standby_o) |-> ($past(commit_w) && cmd_en_o != '0));
endmodule

bind serial_cmd_if scmd_checker #(.N(N)) u_scmd_checker (
    .clk           (clk),
    .rst           (rst),
    .short_i       (short_i),
    .hot_i         (hot_i),
    .cmd_en_o      (cmd_en_o),
    .standby_o     (standby_o),
    .commit_w      (commit_w),
    .short_frame_o (short_frame_o),
    .ninth_clk_o   (ninth_clk_o)
);

// File: tb/test_serial_cmd_if.sv
module test_serial_cmd_if;
    localparam int CLK_P = 10;
    localparam int HALF  = 4;
    localparam int NVEC  = 8;

    typedef struct packed {
        logic [4:0] nclk;
        logic [7:0] data;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{5'd8,  8'hA5},
        '{5'd8,  8'h01},
        '{5'd7,  8'hFF},
        '{5'd9,  8'h3C},
        '{5'd8,  8'h80},
        '{5'd16, 8'h55},
        '{5'd0,  8'h00},
        '{5'd8,  8'h00}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic [7:0] short_f = '0;
    logic [7:0] hot_f = '0;
    logic [7:0] cmd_en;
    logic       standby;
    logic       short_frame;
    logic       ninth;

    int n_cmp = 0;
    int n_bad = 0;
    int n_short_p = 0;
    int n_ninth_p = 0;
    logic [7:0] model = '0;

    always #(CLK_P/2) clk = ~clk;

    serial_cmd_if i_serial_cmd_if (
        .clk           (clk),
        .rst           (rst),
        .cs_n_i        (cs_n),
        .sclk_i        (sclk),
        .sdi_i         (sdi),
        .short_i       (short_f),
        .hot_i         (hot_f),
        .cmd_en_o      (cmd_en),
        .standby_o     (standby),
        .short_frame_o (short_frame),
        .ninth_clk_o   (ninth)
    );

    always @(posedge clk) begin
        if (!rst && short_frame) n_short_p++;
        if (!rst && ninth)       n_ninth_p++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic send_frame(input int n, input logic [7:0] data);
        cs_n = 1'b0;
        wait_cyc(HALF);
        for (int i = 0; i < n; i++) begin
            sdi  = data[i % 8];
            wait_cyc(1);
            sclk = 1'b1;
            wait_cyc(HALF);
            sclk = 1'b0;
            wait_cyc(HALF);
        end
        cs_n = 1'b1;
        wait_cyc(6);
    endtask

    task automatic run_frame(input string req, input int n, input logic [7:0] data);
        send_frame(n, data);
        if (n == 8) model = data & ~(short_f & hot_f);
        model = model & ~(short_f & hot_f);
        check(req, {24'b0, cmd_en}, {24'b0, model});
        check("R6", {31'b0, standby}, {31'b0, (model == 8'h00)});
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int sp0;
        int np0;
        wait_cyc(3);
        // R1: reset state
        check("R1", {24'b0, cmd_en}, 32'h0);
        check("R1", {31'b0, standby}, 32'h1);
        check("R1", {30'b0, short_frame, ninth}, 32'h0);
        rst = 1'b0;
        wait_cyc(3);
        check("R1", {24'b0, cmd_en}, 32'h0);

        // Vector table: R2 exact frames, R4 short, R5 long
        for (int v = 0; v < NVEC; v++) begin
            run_frame((VECS[v].nclk == 5'd8) ? "R2" :
                      (VECS[v].nclk < 5'd8) ? "R4" : "R5",
                      int'(VECS[v].nclk), VECS[v].data);
        end

        // R5: counter wrap case with 24 clocks
        run_frame("R2", 8, 8'h5A);
        sp0 = n_short_p; np0 = n_ninth_p;
        run_frame("R5", 24, 8'hC3);
        check("R10", n_ninth_p - np0, 1);
        check("R9", n_short_p - sp0, 0);

        // R9: short frame pulse, none for exact frame
        sp0 = n_short_p;
        run_frame("R4", 3, 8'hFF);
        check("R9", n_short_p - sp0, 1);
        sp0 = n_short_p; np0 = n_ninth_p;
        run_frame("R2", 8, 8'h96);
        check("R9", n_short_p - sp0, 0);
        check("R10", n_ninth_p - np0, 0);

        // R3: clocks while chip select high
        for (int i = 0; i < 8; i++) begin
            sdi = ~sdi; wait_cyc(1);
            sclk = 1'b1; wait_cyc(HALF);
            sclk = 1'b0; wait_cyc(HALF);
        end
        wait_cyc(4);
        check("R3", {24'b0, cmd_en}, {24'b0, model});
        run_frame("R3", 8, 8'h0F);

        // R7: single flag does not clear; both flags clear and stay cleared
        run_frame("R2", 8, 8'hFF);
        short_f = 8'h10; wait_cyc(4);
        check("R7", {24'b0, cmd_en}, 32'hFF);
        hot_f = 8'h10; wait_cyc(4);
        check("R7", {24'b0, cmd_en}, 32'hEF);
        short_f = 8'h00; hot_f = 8'h00; wait_cyc(4);
        check("R7", {24'b0, cmd_en}, 32'hEF);
        model = 8'hEF;

        // R8: fault held across commit of a byte setting that channel
        short_f = 8'h08; hot_f = 8'h0C;
        run_frame("R8", 8, 8'h3B);
        check("R8", {24'b0, cmd_en}, 32'h33);
        short_f = 8'h00; hot_f = 8'h00; wait_cyc(4);
        check("R8", {24'b0, cmd_en}, 32'h33);

        // R1: reset mid-operation
        rst = 1'b1; wait_cyc(2);
        check("R1", {24'b0, cmd_en}, 32'h0);
        check("R1", {31'b0, standby}, 32'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule